// File: doc/BRIEF.md
# Pipelined SHA-1 Compression Engine

This block computes the SHA-1 compression function on one 512-bit message block per clock. Each of the eighty rounds has its own register stage, so no counter or round controller is needed. A new entry may enter on every cycle. Once the pipe has filled, one 160-bit updated state leaves on every cycle. The caller supplies the starting chaining state with each entry. That state may be the standard initial value or a cached keyed-hash inner or outer state. A caller-defined tag travels with the entry so the result can be matched to its request.

An entry is sampled on a rising edge with `in_valid` high. Its result appears on the outputs after exactly 83 register stages, with `out_valid` high and the same tag. The stages are:

- one input stage, which also pre-adds the first round's constant, message word and E word;
- eighty round stages;
- one stage that adds in the original chaining words;
- one output register.

Cycles with `in_valid` low travel through as bubbles. The caller must do message padding, keyed-hash framing and multi-block sequencing.

Top module: `sha1_compress_pipe`

## Requirements
- R1: While reset is asserted, and after its release until an accepted entry has crossed the pipe, `out_valid` is low.
- R2: An entry sampled with `in_valid` high on a rising edge gives `out_valid` high right after the 83rd rising edge, counting the sampling edge as the first. It does not appear earlier or later.
- R3: Entries offered on consecutive clocks give results on consecutive clocks, one per cycle, in arrival order.
- R4: `out_state` is the SHA-1 compression of `in_block` under `in_state`. This means 80 rounds, with the function and constant changing at rounds 20, 40 and 60 (choose/5A827999, parity/6ED9EBA1, majority/8F1BBCDC, parity/CA62C1D6). After the rounds, each of the five words is added to its matching input word modulo 2^32.
- R5: The chaining state is taken per entry. Neighbouring entries with different starting states each get the result for their own state.
- R6: `out_tag` equals the `in_tag` sampled with the same entry.
- R7: A cycle with `in_valid` low yields `out_valid` low 83 edges later. The block, state and tag present in that cycle have no effect on any other entry's result.
- R8: Message word 0 is at `in_block[511:480]` and word 15 is at `in_block[31:0]`. State word A is at bits [159:128] and word E is at [31:0], in both `in_state` and `out_state`. Each word is big-endian.
- R9: Asserting reset while entries are in flight discards them. None of them produces `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released inside through a two-flop synchronizer |
| in_valid | input | 1 | An entry is offered this cycle |
| in_tag | input | TAG_W | Caller identifier carried with the entry |
| in_block | input | 512 | Sixteen 32-bit message words, word 0 in the top bits |
| in_state | input | 160 | Starting chaining state, word A in the top bits |
| out_valid | output | 1 | A result is present |
| out_tag | output | TAG_W | Tag of the entry whose result is present |
| out_state | output | 160 | Updated chaining state, word A in the top bits |

## Verification
The checker assumes that `in_valid` is never unknown outside reset. It also assumes that `in_block`, `in_state` and `in_tag` are known on any cycle where `in_valid` is high, because otherwise the result-is-known property would not hold. Its latency and streaming windows count edges from the release of the internal synchronized reset, so it assumes that nothing is offered before that release. The stimulus keeps to all of this: it drives known values on every cycle, including random data on bubble cycles, and it holds `in_valid` low through reset and for three cycles after release, which covers the synchronizer delay.

// File: rtl/sha1p_pkg.sv
package sha1p_pkg;

  localparam int WORD_W      = 32;
  localparam int BLK_WORDS   = 16;
  localparam int ST_WORDS    = 5;
  localparam int ROUNDS      = 80;
  localparam int BLOCK_W     = WORD_W * BLK_WORDS;
  localparam int STATE_W     = WORD_W * ST_WORDS;
  // input stage + one stage per round + chaining add + output register
  localparam int LATENCY     = ROUNDS + 3;

  typedef logic [WORD_W-1:0] word_t;

  // Everything an entry carries between round stages.
  typedef struct packed {
    logic [ST_WORDS-1:0][WORD_W-1:0]  wk;   // working words, [4]=A .. [0]=E
    logic [ST_WORDS-1:0][WORD_W-1:0]  cv;   // chaining value kept for the final add
    logic [BLK_WORDS-1:0][WORD_W-1:0] win;  // schedule window, [15] is the current word
    word_t                            pre;  // E + K + W already summed for this round
  } lane_t;

  function automatic word_t rotl(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t round_k(input int r);
    if (r < 20)      return 32'h5A827999;
    else if (r < 40) return 32'h6ED9EBA1;
    else if (r < 60) return 32'h8F1BBCDC;
    else             return 32'hCA62C1D6;
  endfunction

  function automatic word_t round_f(input int r, input word_t b, input word_t c,
                                    input word_t d);
    if (r < 20)                 return (b & c) | (~b & d);
    else if (r >= 40 && r < 60) return (b & c) | (b & d) | (c & d);
    else                        return b ^ c ^ d;
  endfunction

endpackage

// File: rtl/sha1p_round.sv
module sha1p_round
  import sha1p_pkg::*;
#(
  parameter int RND   = 0,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_i,
  input  logic [TAG_W-1:0] tag_i,
  input  lane_t            lane_i,
  output logic             v_o,
  output logic [TAG_W-1:0] tag_o,
  output lane_t            lane_o
);

  word_t a, b, c, d, t_sum, w_new;
  lane_t lane_d;
  logic  v_q;
  logic [TAG_W-1:0] tag_q;
  lane_t lane_q;

  // E is already folded into lane_i.pre by the previous stage
  logic unused_e;
  assign unused_e = ^lane_i.wk[0];

  always_comb begin
    a     = lane_i.wk[4];
    b     = lane_i.wk[3];
    c     = lane_i.wk[2];
    d     = lane_i.wk[1];
    t_sum = rotl(a, 5) + round_f(RND, b, c, d) + lane_i.pre;
    // W[t+16] from the window positions t+13, t+8, t+2 and t
    w_new = rotl(lane_i.win[2] ^ lane_i.win[7] ^ lane_i.win[13] ^ lane_i.win[15], 1);
    lane_d.wk  = {t_sum, a, rotl(b, 30), c, d};
    lane_d.cv  = lane_i.cv;
    lane_d.win = {lane_i.win[BLK_WORDS-2:0], w_new};
    // next round's E is this round's D; its word is window slot 14
    lane_d.pre = d + lane_i.win[14] + round_k(RND + 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      lane_q <= lane_d;
      tag_q  <= tag_i;
    end
  end

  assign v_o    = v_q;
  assign tag_o  = tag_q;
  assign lane_o = lane_q;

endmodule

// File: rtl/sha1p_finish.sv
module sha1p_finish
  import sha1p_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            v_i,
  input  logic [TAG_W-1:0]                tag_i,
  input  logic [ST_WORDS-1:0][WORD_W-1:0] wk_i,
  input  logic [ST_WORDS-1:0][WORD_W-1:0] cv_i,
  output logic                            v_o,
  output logic [TAG_W-1:0]                tag_o,
  output logic [STATE_W-1:0]              state_o
);

  logic [ST_WORDS-1:0][WORD_W-1:0] sum_d, sum_q, out_q;
  logic             sv_q, ov_q;
  logic [TAG_W-1:0] stag_q, otag_q;

  always_comb begin
    for (int i = 0; i < ST_WORDS; i++) sum_d[i] = wk_i[i] + cv_i[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_q <= 1'b0;
      ov_q <= 1'b0;
    end else begin
      sv_q <= v_i;
      ov_q <= sv_q;
    end
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      sum_q  <= sum_d;
      stag_q <= tag_i;
    end
    if (sv_q) begin
      out_q  <= sum_q;
      otag_q <= stag_q;
    end
  end

  assign v_o     = ov_q;
  assign tag_o   = otag_q;
  assign state_o = out_q;

endmodule

// File: rtl/sha1_compress_pipe.sv
module sha1_compress_pipe
  import sha1p_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [TAG_W-1:0]   in_tag,
  input  logic [BLOCK_W-1:0] in_block,
  input  logic [STATE_W-1:0] in_state,
  output logic               out_valid,
  output logic [TAG_W-1:0]   out_tag,
  output logic [STATE_W-1:0] out_state
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  lane_t            lane [0:ROUNDS];
  logic             vld  [0:ROUNDS];
  logic [TAG_W-1:0] tag  [0:ROUNDS];

  // input stage: capture and pre-sum E + K0 + W0
  lane_t            lane0_d;
  lane_t            lane0_q;
  logic             v0_q;
  logic [TAG_W-1:0] tag0_q;

  always_comb begin
    lane0_d.wk  = in_state;
    lane0_d.cv  = in_state;
    lane0_d.win = in_block;
    lane0_d.pre = in_state[WORD_W-1:0] + in_block[BLOCK_W-1 -: WORD_W] + round_k(0);
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) v0_q <= 1'b0;
    else             v0_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      lane0_q <= lane0_d;
      tag0_q  <= in_tag;
    end
  end

  assign lane[0] = lane0_q;
  assign vld[0]  = v0_q;
  assign tag[0]  = tag0_q;

  for (genvar r = 0; r < ROUNDS; r++) begin : g_rnd
    sha1p_round #(.RND(r), .TAG_W(TAG_W)) u_rnd (
      .clk    (clk),
      .rst_n  (core_rst_n),
      .v_i    (vld[r]),
      .tag_i  (tag[r]),
      .lane_i (lane[r]),
      .v_o    (vld[r+1]),
      .tag_o  (tag[r+1]),
      .lane_o (lane[r+1])
    );
  end

  logic unused_tail;
  assign unused_tail = ^{lane[ROUNDS].win, lane[ROUNDS].pre};

  sha1p_finish #(.TAG_W(TAG_W)) u_fin (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .v_i     (vld[ROUNDS]),
    .tag_i   (tag[ROUNDS]),
    .wk_i    (lane[ROUNDS].wk),
    .cv_i    (lane[ROUNDS].cv),
    .v_o     (out_valid),
    .tag_o   (out_tag),
    .state_o (out_state)
  );

endmodule

// File: rtl/sha1_compress_pipe_chk.sv
module sha1_compress_pipe_chk
  import sha1p_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               out_valid,
  input logic [TAG_W-1:0]   out_tag,
  input logic [STATE_W-1:0] out_state
);

  localparam int CW = $clog2(LATENCY + 2);
  localparam logic [CW-1:0] LAT_C = CW'(LATENCY);

  logic [CW-1:0] age_q, run_q, idle_q, infl_q;
  logic [CW-1:0] age_d, run_d, idle_d, infl_d;

  always_comb begin
    age_d  = (age_q == LAT_C) ? age_q : age_q + 1'b1;
    run_d  = !in_valid ? '0 : ((run_q == LAT_C) ? run_q : run_q + 1'b1);
    idle_d = in_valid ? '0 : ((idle_q == LAT_C) ? idle_q : idle_q + 1'b1);
    infl_d = infl_q + CW'(in_valid) - CW'(out_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q  <= '0;
      run_q  <= '0;
      idle_q <= '0;
      infl_q <= '0;
    end else begin
      age_q  <= age_d;
      run_q  <= run_d;
      idle_q <= idle_d;
      infl_q <= infl_d;
    end
  end

  // R1 / R2: nothing can emerge sooner than the full depth after reset
  a_r2_not_early: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q < LAT_C) |-> !out_valid);

  // R3: a run of entries as long as the pipe keeps the output streaming
  a_r3_streaming: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == LAT_C) |-> out_valid);

  // R7: a run of bubbles as long as the pipe empties the output
  a_r7_bubbles: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q == LAT_C) |-> !out_valid);

  // R2 / R9: every result belongs to an accepted, not yet delivered entry
  a_r2_no_orphan: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (infl_q != '0));

  // R3: no more entries in flight than stages
  a_r3_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    infl_q <= LAT_C);

  // R4 / R6: a delivered result and its tag are fully known
  a_r4_known_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown({out_tag, out_state}));

endmodule

bind sha1_compress_pipe sha1_compress_pipe_chk #(.TAG_W(TAG_W)) u_chk (
  .clk       (clk),
  .rst_n     (core_rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_tag   (out_tag),
  .out_state (out_state)
);

// File: tb/tb_sha1_compress_pipe.sv
module tb_sha1_compress_pipe;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 83;
  localparam int TW         = 8;
  localparam int WD_CYCLES  = 20000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [TW-1:0] in_tag;
  logic [511:0]  in_block;
  logic [159:0]  in_state;
  logic          out_valid;
  logic [TW-1:0] out_tag;
  logic [159:0]  out_state;

  always #(CLK_PERIOD/2) clk = ~clk;

  sha1_compress_pipe #(.TAG_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .in_block(in_block), .in_state(in_state),
    .out_valid(out_valid), .out_tag(out_tag), .out_state(out_state)
  );

  typedef struct {
    bit            v;
    logic [TW-1:0] tag;
    logic [159:0]  st;
    string         lab;
  } rec_t;

  rec_t q[$];
  int n_chk  = 0;
  int n_fail = 0;

  localparam logic [159:0] IV =
    160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

  function automatic logic [159:0] ref_compress(logic [511:0] blk, logic [159:0] st);
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, t;
    for (int i = 0; i < 16; i++) w[i] = blk[511 - 32*i -: 32];
    for (int i = 16; i < 80; i++) begin
      t = w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16];
      w[i] = {t[30:0], t[31]};
    end
    a = st[159:128]; b = st[127:96]; c = st[95:64]; d = st[63:32]; e = st[31:0];
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
      else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
      else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
      t = {a[26:0], a[31:27]} + f + e + k + w[i];
      e = d; d = c; c = {b[1:0], b[31:2]}; b = a; a = t;
    end
    return {a + st[159:128], b + st[127:96], c + st[95:64], d + st[63:32], e + st[31:0]};
  endfunction

  function automatic logic [511:0] rnd_block();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [159:0] rnd_state();
    logic [159:0] r;
    for (int i = 0; i < 5; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [159:0] act, logic [159:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one clock: compare the entry driven LAT cycles ago, then drive the next
  task automatic step(bit v, logic [TW-1:0] tg, logic [511:0] blk, logic [159:0] st,
                      string lab);
    rec_t r, e;
    @(negedge clk);
    if (q.size() >= LAT) begin
      e = q.pop_front();
      if (e.v) begin
        chk(out_valid === 1'b1, "R2", "out_valid", {159'd0, out_valid}, 160'd1);
        if (out_valid === 1'b1) begin
          chk(out_tag === e.tag, "R6", "out_tag", {152'd0, out_tag}, {152'd0, e.tag});
          chk(out_state === e.st, e.lab, "out_state", out_state, e.st);
        end
      end else begin
        chk(out_valid === 1'b0, e.lab, "out_valid", {159'd0, out_valid}, 160'd0);
      end
    end
    in_valid = v;
    in_tag   = tg;
    in_block = blk;
    in_state = st;
    r.v   = v;
    r.tag = tg;
    r.st  = v ? ref_compress(blk, st) : 160'd0;
    r.lab = lab;
    q.push_back(r);
  endtask

  task automatic do_reset(string lab);
    rec_t r;
    rst_n = 1'b0;
    q.delete();
    r.v = 1'b0; r.tag = '0; r.st = '0; r.lab = lab;
    repeat (LAT) q.push_back(r);
    repeat (3) step(1'b0, 8'hEE, rnd_block(), rnd_state(), lab);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 8'hEE, rnd_block(), rnd_state(), lab);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [511:0] abc;
    logic [159:0] h_in, h_out;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_tag   = '0;
    in_block = '0;
    in_state = '0;

    // R1: outputs quiet through and after the first reset
    do_reset("R1");

    // R4 / R8: known-answer block "abc" with standard initial value
    abc = '0;
    abc[511:480] = 32'h61626380;
    abc[31:0]    = 32'h00000018;
    chk(ref_compress(abc, IV) ===
        160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D,
        "R4", "reference digest", ref_compress(abc, IV),
        160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D);
    step(1'b1, 8'h5A, abc, IV, "R8");
    repeat (90) step(1'b0, 8'h00, rnd_block(), rnd_state(), "R7");

    // R3: a long back-to-back stream with random data
    for (int i = 0; i < 120; i++) step(1'b1, TW'(i), rnd_block(), rnd_state(), "R3");

    // R5: same block, alternating cached chaining states
    h_in  = rnd_state();
    h_out = rnd_state();
    abc   = rnd_block();
    for (int i = 0; i < 20; i++)
      step(1'b1, TW'(8'h80 + i), abc, (i % 2) ? h_out : h_in, "R5");

    // R7: random bubbles carrying garbage data
    for (int i = 0; i < 80; i++) begin
      bit v = 1'($urandom % 2);
      step(v, TW'($urandom), rnd_block(), rnd_state(), v ? "R4" : "R7");
    end

    // R4: carry-heavy corner values
    step(1'b1, 8'hF0, {512{1'b1}}, {160{1'b1}}, "R4");
    step(1'b1, 8'hF1, '0, '0, "R4");
    step(1'b1, 8'hF2, {512{1'b1}}, '0, "R4");

    // R9: reset while the pipe is partly full
    for (int i = 0; i < 40; i++) step(1'b1, TW'(i), rnd_block(), rnd_state(), "R3");
    do_reset("R9");

    // service resumes after reset
    for (int i = 0; i < 10; i++) step(1'b1, TW'(8'h40 + i), rnd_block(), IV, "R4");
    repeat (LAT + 5) step(1'b0, 8'h00, rnd_block(), rnd_state(), "R7");

    finish_run();
  end

endmodule